// File: doc/BRIEF.md
# Retriggerable Multi-Channel PWM Timer

This block is a 16-bit up-counter that produces up to three pulse-width-modulated outputs and starts only on a trigger. Setting the enable input arms the timer. The counter then waits at its all-ones value until a trigger arrives. A trigger is either a chosen edge on an external input or a one-cycle software strobe. It clears the counter to zero and counting begins. A trigger that arrives while a period is running restarts the period at once.

Compare slot 0 sets the period length. Slots 1 to 3 set how long each output is active at the start of every period. Writes to the compare slots go into pending registers. While the timer is not running, a write reaches the working buffer at once. While it is running, a write takes effect only when the period wraps. The count advances once every 2^sel system clocks, where sel is a 3-bit divider select. Each compare slot has its own match interrupt pulse, one system clock wide.

Top module: `trig_pwm_timer`

## Requirements
- R1: While `enable` is 0, all PWM outputs and interrupt pulses are 0 one clock after `enable` falls, and neither trigger source has any effect.
- R2: With `enable` at 1 and no trigger yet, the timer stays idle: PWM outputs and interrupts remain 0 however long it waits.
- R3: A `sw_trig` pulse sampled at a clock edge starts the period at that edge. The count is 0 after the edge, and every output whose buffered width is nonzero is high from that edge on.
- R4: `edge_sel` picks the external trigger edge: 0 = rising, 1 = falling, 2 = both, 3 = none. A selected edge on `ext_trig` starts the period on the third rising clock edge after the input changes. An edge that is not selected is ignored.
- R5: A period lasts (slot0 + 1) counts, and one count lasts 2^`clk_sel` system clocks. After the count matching slot 0, the counter returns to 0.
- R6: Output k (k = 1..3, driven on `pwm_out[k-1]`) is high during counts 0 to slotk - 1 of each period and low for the rest. It stays low for the whole period when slotk = 0, and stays high for the whole period when slotk > slot0.
- R7: `irq[0]` is a single-system-clock pulse in the first clock of the count that wraps to 0. It is not raised by a trigger.
- R8: `irq[k]` (k = 1..3) is a single-system-clock pulse in the first clock of the count equal to the buffered slotk. This includes count 0 at a trigger or a wrap.
- R9: A trigger while the counter runs restarts the period at once, with the same timing as R3.
- R10: `cmp_wr` stores `cmp_wdata` into the slot chosen by `cmp_idx` (0 = period, 1..3 = outputs 1..3). While the timer is not running, the stored value is used from the next count on. While it is running, the value is used only from the wrap to 0 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the timer; 0 stops it |
| clk_sel | input | 3 | Count clock = system clock / 2^clk_sel |
| edge_sel | input | 2 | External trigger edge: 0 rising, 1 falling, 2 both, 3 none |
| ext_trig | input | 1 | Asynchronous external trigger input |
| sw_trig | input | 1 | Software trigger strobe |
| cmp_wr | input | 1 | Compare slot write strobe |
| cmp_idx | input | 2 | Compare slot index (0 period, 1..3 outputs) |
| cmp_wdata | input | 16 | Compare slot write value |
| pwm_out | output | 3 | PWM outputs for channels 1..3 |
| irq | output | 4 | Per-slot compare-match pulses |

## Verification
A wrong count or a wrong buffer shows up within one period as a PWM edge at the wrong place and as a match pulse in the wrong cycle. The bench compares every output and every interrupt bit on every clock of each window against a count it works out itself from the clock, so one stray cycle is caught in the clock where it happens. A reload taken too early shows up before the wrap as a changed period, and a missed retrigger shows up one clock after the trigger. The external-edge checks sample the cycle just before the expected start as well as the start itself, so a synchronizer stage that is missing or added is caught.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_NONE = 2'd3
    } edge_mode_e;

endpackage

// File: rtl/tpwm_prescale.sv
module tpwm_prescale #(
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            restart,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    localparam int DIVW = (1 << SELW) - 1;

    typedef struct packed {
        logic [DIVW-1:0] div;
    } ps_state_t;

    ps_state_t       st_q, st_d;
    logic [DIVW-1:0] mask;

    always_comb begin
        mask = ~({DIVW{1'b1}} << sel);
        tick = run_en && ((st_q.div & mask) == mask);
        st_d = st_q;
        if (!run_en || restart || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tpwm_trig_detect.sv
module tpwm_trig_detect
    import tpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] edge_sel,
    input  logic       ext_in,
    input  logic       sw_strobe,
    output logic       trig
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } td_state_t;

    td_state_t  st_q, st_d;
    logic       rise, fall, ext_edge;
    edge_mode_e mode;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ext_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        rise      = st_q.s2 && !st_q.prev;
        fall      = !st_q.s2 && st_q.prev;
        mode      = edge_mode_e'(edge_sel);
        case (mode)
            EDGE_RISE: ext_edge = rise;
            EDGE_FALL: ext_edge = fall;
            EDGE_BOTH: ext_edge = rise || fall;
            default:   ext_edge = 1'b0;
        endcase
        trig = enable && (sw_strobe || ext_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tpwm_cmp_bank.sv
module tpwm_cmp_bank #(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [$clog2(NCH+1)-1:0] wr_idx,
    input  logic [CW-1:0]           wr_data,
    input  logic                    running,
    input  logic                    load,
    output logic [NCH:0][CW-1:0]    bufs_q,
    output logic [NCH:0][CW-1:0]    bufs_d
);
    typedef struct packed {
        logic [NCH:0][CW-1:0] pend;
        logic [NCH:0][CW-1:0] bufs;
    } cb_state_t;

    cb_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr && (int'(wr_idx) <= NCH)) begin
            st_d.pend[wr_idx] = wr_data;
        end
        if (!running || load) begin
            st_d.bufs = st_d.pend;
        end
        bufs_q = st_q.bufs;
        bufs_d = st_d.bufs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tpwm_core.sv
module tpwm_core #(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 trig,
    input  logic                 tick,
    input  logic [NCH:0][CW-1:0] bufs_q,
    input  logic [NCH:0][CW-1:0] bufs_d,
    output logic                 load,
    output logic [CW-1:0]        cnt,
    output logic                 running,
    output logic [NCH-1:0]       pwm,
    output logic [NCH:0]         irq
);
    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic           run;
        logic [NCH-1:0] pwm;
        logic [NCH:0]   irq;
    } core_state_t;

    core_state_t st_q, st_d;
    logic        wrap, advance;

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        wrap     = st_q.run && tick && (st_q.cnt == bufs_q[0]);
        load     = wrap;
        advance  = 1'b0;
        if (!enable) begin
            st_d.cnt = '1;
            st_d.run = 1'b0;
        end else if (trig) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
            advance  = 1'b1;
        end else if (st_q.run && tick) begin
            st_d.cnt    = wrap ? '0 : st_q.cnt + 1'b1;
            st_d.irq[0] = wrap;
            advance     = 1'b1;
        end
        for (int k = 0; k < NCH; k++) begin
            st_d.pwm[k]   = st_d.run && (st_d.cnt < bufs_d[k+1]);
            st_d.irq[k+1] = advance && (st_d.cnt == bufs_d[k+1]);
        end
        cnt     = st_q.cnt;
        running = st_q.run;
        pwm     = st_q.pwm;
        irq     = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer #(
    parameter int CW   = 16,
    parameter int NCH  = 3,
    parameter int SELW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [SELW-1:0]          clk_sel,
    input  logic [1:0]               edge_sel,
    input  logic                     ext_trig,
    input  logic                     sw_trig,
    input  logic                     cmp_wr,
    input  logic [$clog2(NCH+1)-1:0] cmp_idx,
    input  logic [CW-1:0]            cmp_wdata,
    output logic [NCH-1:0]           pwm_out,
    output logic [NCH:0]             irq
);
    logic                 trig;
    logic                 tick;
    logic                 load;
    logic                 running;
    logic [CW-1:0]        cnt;
    logic [NCH:0][CW-1:0] cmp_buf;
    logic [NCH:0][CW-1:0] cmp_buf_nxt;

    tpwm_trig_detect i_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .edge_sel  (edge_sel),
        .ext_in    (ext_trig),
        .sw_strobe (sw_trig),
        .trig      (trig)
    );

    tpwm_prescale #(.SELW(SELW)) i_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (enable),
        .restart (trig),
        .sel     (clk_sel),
        .tick    (tick)
    );

    tpwm_cmp_bank #(.CW(CW), .NCH(NCH)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmp_wr),
        .wr_idx  (cmp_idx),
        .wr_data (cmp_wdata),
        .running (running),
        .load    (load),
        .bufs_q  (cmp_buf),
        .bufs_d  (cmp_buf_nxt)
    );

    tpwm_core #(.CW(CW), .NCH(NCH)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .trig    (trig),
        .tick    (tick),
        .bufs_q  (cmp_buf),
        .bufs_d  (cmp_buf_nxt),
        .load    (load),
        .cnt     (cnt),
        .running (running),
        .pwm     (pwm_out),
        .irq     (irq)
    );
endmodule

// File: rtl/trig_pwm_timer_chk.sv
module trig_pwm_timer_chk #(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 trig,
    input logic                 tick,
    input logic                 running,
    input logic [CW-1:0]        cnt,
    input logic [NCH:0][CW-1:0] bufs,
    input logic [NCH-1:0]       pwm,
    input logic [NCH:0]         irq
);
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwm == '0 && irq == '0));

    p_idle_at_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running) |-> (cnt == '1));

    p_trig_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (running && cnt == '0));

    p_period_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !trig && running && tick && cnt == bufs[0]) |=> (cnt == '0));

    p_zero_width_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bufs[1] == '0) |-> !pwm[0]);

    p_wrap_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (running && cnt == '0));

    p_ch_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (cnt == bufs[1]));

    p_buffers_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(tick && cnt == bufs[0])) |=> $stable(bufs));
endmodule

bind trig_pwm_timer trig_pwm_timer_chk #(.CW(CW), .NCH(NCH)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .trig    (trig),
    .tick    (tick),
    .running (running),
    .cnt     (cnt),
    .bufs    (cmp_buf),
    .pwm     (pwm_out),
    .irq     (irq)
);

// File: tb/test_trig_pwm_timer.sv
`timescale 1ns/1ps
module test_trig_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic [1:0]  edge_sel = 2'd0;
    logic        ext_trig = 1'b0;
    logic        sw_trig = 1'b0;
    logic        cmp_wr = 1'b0;
    logic [1:0]  cmp_idx = 2'd0;
    logic [15:0] cmp_wdata = 16'd0;
    logic [2:0]  pwm_out;
    logic [3:0]  irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    trig_pwm_timer i_trig_pwm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .clk_sel   (clk_sel),
        .edge_sel  (edge_sel),
        .ext_trig  (ext_trig),
        .sw_trig   (sw_trig),
        .cmp_wr    (cmp_wr),
        .cmp_idx   (cmp_idx),
        .cmp_wdata (cmp_wdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {pwm,irq} got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            check(tag, {pwm_out, irq}, 7'd0);
            @(negedge clk);
        end
    endtask

    // Expected behaviour from R5..R8: count = (i / 2^sel) mod (p+1).
    task automatic check_window(input string tag, input int sel, input int p,
                                input int c1, input int c2, input int c3,
                                input int i0, input int n, input bit tstart);
        for (int i = i0; i < i0 + n; i++) begin
            int         step;
            int         cv;
            bit         ns;
            logic [2:0] ep;
            logic [3:0] ei;
            step  = 1 << sel;
            cv    = (i / step) % (p + 1);
            ns    = (i % step) == 0;
            ep    = {cv < c3, cv < c2, cv < c1};
            ei[0] = ns && cv == 0 && !(tstart && i == 0);
            ei[1] = ns && cv == c1;
            ei[2] = ns && cv == c2;
            ei[3] = ns && cv == c3;
            check(tag, {pwm_out, irq}, {ep, ei});
            @(negedge clk);
        end
    endtask

    task automatic wr_cmp(input int idx, input int val);
        cmp_wr    = 1'b1;
        cmp_idx   = 2'(idx);
        cmp_wdata = 16'(val);
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", {pwm_out, irq}, 7'd0);
        wr_cmp(0, 9); wr_cmp(1, 3); wr_cmp(2, 0); wr_cmp(3, 12);
        check_quiet("R1 disabled after writes", 3);
    endtask

    task automatic t_idle();
        enable = 1'b1;
        @(negedge clk);
        check_quiet("R2 armed idle", 20);
    endtask

    task automatic t_sw_trigger();
        pulse_sw();
        check_window("R3 R5 R6 R7 R8 sw start", 0, 9, 3, 0, 12, 0, 25, 1'b1);
    endtask

    task automatic t_retrigger();
        pulse_sw();
        check_window("R9 before retrigger", 0, 9, 3, 0, 12, 0, 5, 1'b1);
        pulse_sw();
        check_window("R9 after retrigger", 0, 9, 3, 0, 12, 0, 22, 1'b1);
    endtask

    task automatic t_reload();
        pulse_sw();
        check_window("R10 before write", 0, 9, 3, 0, 12, 0, 3, 1'b1);
        wr_cmp(0, 4);
        wr_cmp(1, 2);
        check_window("R10 old values kept", 0, 9, 3, 0, 12, 5, 5, 1'b1);
        check_window("R10 new values at wrap", 0, 4, 2, 0, 12, 0, 15, 1'b0);
    endtask

    task automatic t_disable();
        enable = 1'b0;
        @(negedge clk);
        check_quiet("R1 stop", 2);
        pulse_sw();
        check_quiet("R1 sw trigger ignored", 5);
        wr_cmp(0, 9); wr_cmp(1, 3);
        enable = 1'b1;
        @(negedge clk);
        check_quiet("R2 rearmed idle", 5);
    endtask

    task automatic t_ext_edges();
        edge_sel = 2'd1;
        ext_trig = 1'b1;
        check_quiet("R4 rising ignored in falling mode", 8);
        edge_sel = 2'd0;
        ext_trig = 1'b0;
        check_quiet("R4 falling ignored in rising mode", 8);
        ext_trig = 1'b1;
        check_quiet("R4 rising latency", 3);
        check_window("R4 rising start", 0, 9, 3, 0, 12, 0, 4, 1'b1);
        ext_trig = 1'b0;
        check_window("R4 falling no restart", 0, 9, 3, 0, 12, 4, 16, 1'b1);
        edge_sel = 2'd1;
        ext_trig = 1'b1;
        check_window("R4 rising no restart", 0, 9, 3, 0, 12, 20, 6, 1'b1);
        ext_trig = 1'b0;
        check_window("R4 falling latency", 0, 9, 3, 0, 12, 26, 3, 1'b1);
        check_window("R4 falling start", 0, 9, 3, 0, 12, 0, 7, 1'b1);
        edge_sel = 2'd2;
        ext_trig = 1'b1;
        check_window("R4 both latency", 0, 9, 3, 0, 12, 7, 3, 1'b1);
        check_window("R4 both start", 0, 9, 3, 0, 12, 0, 6, 1'b1);
        edge_sel = 2'd3;
        ext_trig = 1'b0;
        check_window("R4 none mode ignored", 0, 9, 3, 0, 12, 6, 14, 1'b1);
    endtask

    task automatic t_prescale();
        enable = 1'b0;
        @(negedge clk);
        clk_sel = 3'd2;
        wr_cmp(0, 3); wr_cmp(1, 1); wr_cmp(2, 4); wr_cmp(3, 2);
        enable = 1'b1;
        @(negedge clk);
        pulse_sw();
        check_window("R5 R6 R8 prescaled", 2, 3, 1, 4, 2, 0, 40, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_sw_trigger();
        t_retrigger();
        t_reload();
        t_disable();
        t_ext_edges();
        t_prescale();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule